// File: doc/BRIEF.md
# Fixed-Point Forward-Euler Integrator for a Scalar Linear ODE

This block integrates the scalar equation du/dt = a·u + b numerically with the explicit forward Euler method. It works in signed two's-complement fixed point: every operand is a Q4.12 word, which has 4 integer bits including the sign and 12 fraction bits. The host supplies the coefficient, the bias, the starting value, a precomputed step size (total simulated time divided by the number of steps) and the number of steps, then pulses a start strobe.

Each step takes two clock cycles. In the first cycle the block forms the slope a·u + b from the present state. In the second it advances the state by step·slope and presents the new state with a one-cycle valid strobe. The slope is kept at full width, so the only place where a value can leave the representable range is the state update. There the result is clamped to the largest or smallest Q4.12 value and a sticky saturation flag is raised. A done strobe marks the final step. A start strobe that arrives while a run is in progress has no effect.

Top module: `euler_stepper`

## Requirements
- R1: A start pulse seen while `busy` is low is accepted. On the next cycle `u_out` equals `u_init`, `sat_flag` is 0, and `busy` is 1 when `step_count` is nonzero. The operands are latched at acceptance, so later changes to the inputs do not affect the run.
- R2: The slope of each step is floor(a·u / 4096) + b, taken from the current state u. The product a·u is kept at full width, and the division by 4096 rounds toward negative infinity.
- R3: The new state is u + floor(h·slope / 4096), using the same rounding.
- R4: After an accepted start at clock edge k, `u_valid` is high for exactly one cycle after each edge k+2i, for i = 1..step_count. At those times `u_out` shows the state after step i. `u_valid` is low at every other time.
- R5: `done` is high for exactly one cycle: the cycle of the last `u_valid` pulse. `busy` is low in that cycle.
- R6: An update result above 32767 (0x7FFF) is stored as 32767, and one below -32768 (0x8000) is stored as -32768. Either case sets `sat_flag`, which stays high until the next accepted start.
- R7: A start pulse while `busy` is high is ignored. The run in progress keeps its operands, step count and timing.
- R8: An accepted start with `step_count` = 0 pulses `done` in the next cycle and produces no `u_valid`. `u_out` then holds `u_init`, and `busy` stays low.
- R9: After reset, `u_out` is 0 and `busy`, `u_valid`, `done` and `sat_flag` are all low.
- R10: While `busy` is low and no start is given, `u_out` and `sat_flag` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start strobe; acts only while idle |
| coef_a | input | 16 | Coefficient a, Q4.12 |
| bias_b | input | 16 | Bias b, Q4.12 |
| u_init | input | 16 | Initial state, Q4.12 |
| step_h | input | 16 | Step size h, Q4.12 |
| step_count | input | 16 | Number of Euler steps, unsigned |
| busy | output | 1 | High while steps remain |
| u_out | output | 16 | Current state, Q4.12 |
| u_valid | output | 1 | One-cycle pulse after every update |
| done | output | 1 | One-cycle pulse with the last update |
| sat_flag | output | 1 | Sticky saturation indicator |

## Verification
The hardest case to reach is a clamp at the update stage while the slope itself is still in range. This takes a large bias or coefficient together with a step size near 1.0. In a random draw the product of those terms rarely crosses the boundary, and hardly ever in both directions. Directed runs therefore push the state toward each limit from a value already close to it. They also check that the flag survives the remaining steps and clears on the next run. Floor rounding of negative products, a start injected in the middle of a run with different operands, and a zero step count are driven as directed cases. Seeded random runs cover general operand mixes.

// File: rtl/euler_pkg.sv
package euler_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_SLOPE  = 2'd1,
      ST_ADVANCE = 2'd2
   } euler_state_e;
endpackage

// File: rtl/euler_slope.sv
module euler_slope #(
   parameter int DATA_W  = 16,
   parameter int FRAC_W  = 12,
   parameter int SLOPE_W = 2*DATA_W-FRAC_W+1
) (
   input  logic signed [DATA_W-1:0]  coef,
   input  logic signed [DATA_W-1:0]  state,
   input  logic signed [DATA_W-1:0]  bias,
   output logic signed [SLOPE_W-1:0] slope
);
   localparam int PROD_W = 2*DATA_W;
   localparam int SCL_W  = PROD_W-FRAC_W;

   logic signed [PROD_W-1:0] prod;
   logic signed [SCL_W-1:0]  scaled;

   always_comb begin
      prod   = coef * state;
      scaled = prod[PROD_W-1:FRAC_W];
      slope  = SLOPE_W'(scaled) + SLOPE_W'(bias);
   end
endmodule

// File: rtl/euler_advance.sv
module euler_advance #(
   parameter int DATA_W  = 16,
   parameter int FRAC_W  = 12,
   parameter int SLOPE_W = 2*DATA_W-FRAC_W+1
) (
   input  logic signed [DATA_W-1:0]  step,
   input  logic signed [SLOPE_W-1:0] slope,
   input  logic signed [DATA_W-1:0]  state,
   output logic signed [DATA_W-1:0]  next_state,
   output logic                      clamped
);
   localparam int PROD_W = DATA_W+SLOPE_W;
   localparam int SCL_W  = PROD_W-FRAC_W;
   localparam int SUM_W  = SCL_W+1;
   localparam int EXT_W  = SUM_W-DATA_W+1;

   localparam logic signed [SUM_W-1:0] TOP_V = {{EXT_W{1'b0}}, {(DATA_W-1){1'b1}}};
   localparam logic signed [SUM_W-1:0] BOT_V = {{EXT_W{1'b1}}, {(DATA_W-1){1'b0}}};

   logic signed [PROD_W-1:0] prod;
   logic signed [SCL_W-1:0]  scaled;
   logic signed [SUM_W-1:0]  sum;
   logic                     over_hi;
   logic                     over_lo;

   always_comb begin
      prod    = step * slope;
      scaled  = prod[PROD_W-1:FRAC_W];
      sum     = SUM_W'(scaled) + SUM_W'(state);
      over_hi = sum > TOP_V;
      over_lo = sum < BOT_V;
      clamped = over_hi | over_lo;
   end

   generate
      if (SUM_W > DATA_W) begin : g_clamp
         always_comb begin
            if (over_hi)      next_state = TOP_V[DATA_W-1:0];
            else if (over_lo) next_state = BOT_V[DATA_W-1:0];
            else              next_state = sum[DATA_W-1:0];
         end
      end else begin : g_bad_width
         $error("euler_advance: sum width must exceed the data width");
      end
   endgenerate
endmodule

// File: rtl/euler_seq.sv
module euler_seq import euler_pkg::*; #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] count,
   output logic             accept,
   output logic             slope_en,
   output logic             adv_en,
   output logic             busy,
   output logic             done
);
   euler_state_e     state_q;
   logic [CNT_W-1:0] total_q;
   logic [CNT_W-1:0] idx_q;
   logic             last;

   always_comb begin
      accept   = start && (state_q == ST_IDLE);
      slope_en = (state_q == ST_SLOPE);
      adv_en   = (state_q == ST_ADVANCE);
      busy     = (state_q != ST_IDLE);
      last     = (idx_q == total_q - 1'b1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         total_q <= '0;
         idx_q   <= '0;
         done    <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  total_q <= count;
                  idx_q   <= '0;
                  if (count == '0) done    <= 1'b1;
                  else             state_q <= ST_SLOPE;
               end
            end
            ST_SLOPE:   state_q <= ST_ADVANCE;
            ST_ADVANCE: begin
               if (last) begin
                  done    <= 1'b1;
                  state_q <= ST_IDLE;
               end else begin
                  idx_q   <= idx_q + 1'b1;
                  state_q <= ST_SLOPE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/euler_stepper.sv
module euler_stepper import euler_pkg::*; #(
   parameter int DATA_W = 16,
   parameter int FRAC_W = 12,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [DATA_W-1:0] coef_a,
   input  logic [DATA_W-1:0] bias_b,
   input  logic [DATA_W-1:0] u_init,
   input  logic [DATA_W-1:0] step_h,
   input  logic [CNT_W-1:0]  step_count,
   output logic              busy,
   output logic [DATA_W-1:0] u_out,
   output logic              u_valid,
   output logic              done,
   output logic              sat_flag
);
   localparam int SLOPE_W = 2*DATA_W-FRAC_W+1;

   generate
      if (FRAC_W < 1 || FRAC_W >= DATA_W) begin : g_bad_frac
         $error("euler_stepper: FRAC_W must lie in 1..DATA_W-1");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("euler_stepper: CNT_W must be at least 1");
      end
   endgenerate

   logic signed [DATA_W-1:0]  a_q, b_q, h_q, u_q;
   logic signed [SLOPE_W-1:0] slope_d, slope_q;
   logic signed [DATA_W-1:0]  u_next;
   logic                      clamp;
   logic                      accept, slope_en, adv_en;
   logic                      valid_q, sat_q;

   euler_seq #(.CNT_W(CNT_W)) i_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .count    (step_count),
      .accept   (accept),
      .slope_en (slope_en),
      .adv_en   (adv_en),
      .busy     (busy),
      .done     (done)
   );

   euler_slope #(.DATA_W(DATA_W), .FRAC_W(FRAC_W), .SLOPE_W(SLOPE_W)) i_slope (
      .coef  (a_q),
      .state (u_q),
      .bias  (b_q),
      .slope (slope_d)
   );

   euler_advance #(.DATA_W(DATA_W), .FRAC_W(FRAC_W), .SLOPE_W(SLOPE_W)) i_adv (
      .step       (h_q),
      .slope      (slope_q),
      .state      (u_q),
      .next_state (u_next),
      .clamped    (clamp)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_q     <= '0;
         b_q     <= '0;
         h_q     <= '0;
         u_q     <= '0;
         slope_q <= '0;
         valid_q <= 1'b0;
         sat_q   <= 1'b0;
      end else begin
         valid_q <= adv_en;
         if (accept) begin
            a_q   <= coef_a;
            b_q   <= bias_b;
            h_q   <= step_h;
            u_q   <= u_init;
            sat_q <= 1'b0;
         end
         if (slope_en) slope_q <= slope_d;
         if (adv_en) begin
            u_q   <= u_next;
            sat_q <= sat_q | clamp;
         end
      end
   end

   assign u_out    = u_q;
   assign u_valid  = valid_q;
   assign sat_flag = sat_q;
endmodule

// File: rtl/euler_stepper_chk.sv
module euler_stepper_chk #(
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              busy,
   input logic [DATA_W-1:0] u_out,
   input logic              u_valid,
   input logic              done,
   input logic              sat_flag
);
   AST_VALID_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
      u_valid |=> !u_valid);                                         // R4
   AST_VALID_FROM_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      u_valid |-> $past(busy));                                      // R4
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);                                               // R5
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);                                               // R5
   AST_SAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (sat_flag && !(start && !busy)) |=> sat_flag);                 // R6
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> ($stable(u_out) && $stable(sat_flag)));  // R10
endmodule

bind euler_stepper euler_stepper_chk #(.DATA_W(DATA_W)) i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .busy     (busy),
   .u_out    (u_out),
   .u_valid  (u_valid),
   .done     (done),
   .sat_flag (sat_flag)
);

// File: tb/test_euler_stepper.sv
module test_euler_stepper;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [15:0] coef_a = '0, bias_b = '0, u_init = '0, step_h = '0, step_count = '0;
   logic        busy, u_valid, done, sat_flag;
   logic [15:0] u_out;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   euler_stepper i_euler_stepper (
      .clk(clk), .rst_n(rst_n), .start(start), .coef_a(coef_a), .bias_b(bias_b),
      .u_init(u_init), .step_h(step_h), .step_count(step_count), .busy(busy),
      .u_out(u_out), .u_valid(u_valid), .done(done), .sat_flag(sat_flag)
   );

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // Returns the next state; sets sat when clamped (R2, R3, R6)
   function automatic longint ref_step(input longint a, input longint b, input longint u,
                                       input longint h, inout bit sat);
      longint slope, nu;
      slope = ((a * u) >>> 12) + b;
      nu = u + ((h * slope) >>> 12);
      if (nu > 32767)  begin nu = 32767;  sat = 1'b1; end
      if (nu < -32768) begin nu = -32768; sat = 1'b1; end
      return nu;
   endfunction

   task automatic run(input int a, input int b, input int u0, input int h, input int n,
                      input bit poke);
      longint mu = u0;
      bit msat = 1'b0;
      @(negedge clk);
      coef_a = 16'(a); bias_b = 16'(b); u_init = 16'(u0); step_h = 16'(h);
      step_count = 16'(n); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk($signed(u_out) == u0, "R1 u_out loads u_init", $signed(u_out), u0);
      chk(sat_flag == 1'b0, "R1 sat_flag clears", sat_flag, 0);
      chk(busy == (n != 0), "R1 busy after start", busy, n != 0);
      if (n == 0) begin
         chk(done == 1'b1, "R8 done for zero steps", done, 1);
         chk(u_valid == 1'b0, "R8 no u_valid", u_valid, 0);
      end
      if (poke && n > 0) begin
         // R7: start during run with different operands
         coef_a = ~coef_a; bias_b = 16'h4000; u_init = 16'h1234; step_h = 16'h0800;
         step_count = 16'd1; start = 1'b1;
      end
      for (int j = 1; j <= 2*n + 3; j++) begin
         @(negedge clk);
         start = 1'b0;
         if (j % 2 == 0 && j / 2 <= n) begin
            mu = ref_step(a, b, mu, h, msat);
            chk(u_valid == 1'b1, poke ? "R7 u_valid timing" : "R4 u_valid pulse", u_valid, 1);
            chk($signed(u_out) == mu, poke ? "R7 state unaffected" : "R3 state update",
                $signed(u_out), mu);
            chk(done == (j / 2 == n), "R5 done with last step", done, j / 2 == n);
            if (j / 2 == n) chk(busy == 1'b0, "R5 busy low at done", busy, 0);
         end else begin
            chk(u_valid == 1'b0, "R4 u_valid idle", u_valid, 0);
            chk(done == 1'b0, "R5 done idle", done, 0);
         end
      end
      chk(sat_flag == msat, "R6 sat_flag after run", sat_flag, msat);
      chk(busy == 1'b0, "R4 idle after run", busy, 0);
      if (n == 0) chk($signed(u_out) == u0, "R8 u_out holds u_init", $signed(u_out), u0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [15:0] held;
      bit          held_sat;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      chk(u_out == 16'd0, "R9 reset u_out", u_out, 0);
      chk({busy, u_valid, done, sat_flag} == 4'b0, "R9 reset flags",
          {busy, u_valid, done, sat_flag}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 floor rounding of a negative product: a=-1/4096, u=1/4096
      run(-1, 0, 1, 4096, 2, 1'b0);
      // R2 general slope with decay
      run(-2048, 1024, 4096, 512, 6, 1'b0);
      // R6 upper clamp, then flag stays through later steps
      run(0, 32767, 28672, 4096, 3, 1'b0);
      // R6 flag clears on the next accepted start
      run(0, 16, 100, 256, 2, 1'b0);
      // R6 lower clamp
      run(4096, -32768, -30000, 4096, 2, 1'b0);
      // R7 start while busy is ignored
      run(1000, -500, 2000, 1024, 4, 1'b1);
      // R8 zero steps
      run(1234, 5678, -4321, 4096, 0, 1'b0);

      // R10 idle hold with changing inputs and no start
      held = u_out; held_sat = sat_flag;
      coef_a = 16'h7FFF; u_init = 16'h5555;
      repeat (3) @(negedge clk);
      chk(u_out == held, "R10 u_out stable while idle", u_out, held);
      chk(sat_flag == held_sat, "R10 sat_flag stable while idle", sat_flag, held_sat);

      for (int k = 0; k < 30; k++) begin
         int ra, rb, ru, rh, rn;
         ra = int'($urandom_range(0, 8191)) - 4096;
         rb = int'($urandom_range(0, 65535)) - 32768;
         ru = int'($urandom_range(0, 65535)) - 32768;
         rh = int'($urandom_range(0, 4096));
         rn = int'($urandom_range(1, 12));
         run(ra, rb, ru, rh, rn, k % 7 == 3);
      end

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule